// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block drives a fixed-geometry true-colour display from a linear frame buffer in memory. An internal raster counter walks a standard 640x480 timing grid (800 clocks per line, 525 lines per frame) and, for every visible position while the display is switched on, presents a word-aligned read address and a request strobe to the memory side. The returned 32-bit word is split into 8-bit red, green and blue channels and sent out together with a data-enable flag and active-low horizontal and vertical sync, all delayed by the same two clocks so they stay aligned.

Software sees two write-only registers: a buffer base at byte offset 0 and a control word at byte offset 4. Only the top 11 bits of the base are kept, so the buffer always starts on a 2 MiB boundary. Each display row occupies 1024 words in memory, of which the first 640 are shown. A control bit turns the display on; a second control bit mirrors scanout in both directions, giving a 180-degree turn of the picture. Register writes are staged and only reach the scanout logic at the start of the next frame, so a frame is never drawn with a mix of two settings.

Top module: `fbscan_top`

## Requirements
- R1: The raster repeats every H_TOTAL clocks per line and V_TOTAL lines per frame (defaults 800 and 525); positions with column < H_ACTIVE and row < V_ACTIVE are visible; hsync_n is low for the H_SYNC columns that follow the H_ACTIVE+H_FRONT visible and front-porch columns, and vsync_n is low for the V_SYNC lines that follow the V_ACTIVE+V_FRONT lines.
- R2: A write at byte offset 0 updates the base, a write at byte offset 4 updates the control word, and a write at any other offset changes nothing.
- R3: Only base bits 31:21 are kept; bits 20:0 of a written base are treated as zero.
- R4: With control bit 0 set and rotation off, each visible position (row, col) issues one read with mem_rd_addr = base + 4*(row*1024 + col); no read is issued outside the visible area.
- R5: With control bits 1 and 0 both set, the read for visible position (row, col) uses row' = V_ACTIVE-1-row and col' = H_ACTIVE-1-col in the same formula.
- R6: With control bit 0 clear (including after writing zero to the control word), mem_rd_valid stays low and the colour outputs are zero.
- R7: A register write changes the reads and outputs only from the first position of the following frame; the rest of the current frame keeps the old settings.
- R8: The word returned one clock after a read appears two clocks after the request as red = bits 23:16, green = bits 15:8, blue = bits 7:0; bits 31:24 have no effect; pix_de, pix_hsync_n and pix_vsync_n carry the same two-clock delay.
- R9: Outside the visible area pix_de is low and all colour outputs are zero.
- R10: After reset the display is off, the base is zero, the raster is at row 0 column 0, no read is requested, pix_de and colours are zero and both syncs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register byte offset (0 base, 4 control) |
| reg_wr_data | input | 32 | Register write data |
| mem_rd_valid | output | 1 | Pixel read request |
| mem_rd_addr | output | 32 | Byte address of the requested pixel word |
| mem_rd_data | input | 32 | Pixel word, one clock after the request |
| pix_de | output | 1 | Visible-area flag, aligned with colours |
| pix_red | output | 8 | Red level |
| pix_green | output | 8 | Green level |
| pix_blue | output | 8 | Blue level |
| pix_hsync_n | output | 1 | Horizontal sync, active low |
| pix_vsync_n | output | 1 | Vertical sync, active low |

## Verification
A corrupted raster count shows up within one clock as a request address that breaks the +4 (or -4 when rotated) step between neighbouring pixels, and two clocks later as misplaced sync edges or data-enable. A wrong staged or live setting is invisible until the next frame boundary, then shows at once at the first visible pixel as a wrong base, a missing or extra request, or reversed scan direction. A slip in the output pipeline shows on the first visible pixel of a line as colours paired with the wrong address or with a low data-enable.

// File: rtl/fbscan_pkg.sv
// Shared widths and the scanout setting record.
// Assumes a 32-bit byte-addressed memory and 32-bit pixel words.
package fbscan_pkg;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int COLOR_W = 8;
    localparam int REG_AW  = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              rot;
        logic              en;
    } scan_cfg_t;
endpackage

// File: rtl/fbscan_raster.sv
// Raster position counter with sync generation.
// Assumes sync pulses fall inside the blanking interval (FRONT, SYNC >= 1).
module fbscan_raster #(
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BACK   = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 33,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt_o,
    output logic [VW-1:0] v_cnt_o,
    output logic          active_o,
    output logic          hsync_n_o,
    output logic          vsync_n_o,
    output logic          frame_end_o
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] HS_BEG = HW'(H_ACTIVE + H_FRONT);
    localparam logic [HW-1:0] HS_END = HW'(H_ACTIVE + H_FRONT + H_SYNC);
    localparam logic [VW-1:0] VS_BEG = VW'(V_ACTIVE + V_FRONT);
    localparam logic [VW-1:0] VS_END = VW'(V_ACTIVE + V_FRONT + V_SYNC);

    // Advance column every clock, row on column wrap, both wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt_o <= '0;
            v_cnt_o <= '0;
        end else if (h_cnt_o == H_LAST) begin
            h_cnt_o <= '0;
            v_cnt_o <= (v_cnt_o == V_LAST) ? '0 : v_cnt_o + 1'b1;
        end else begin
            h_cnt_o <= h_cnt_o + 1'b1;
        end
    end

    // Decode visibility, sync windows and the last position of the frame.
    always_comb begin
        active_o    = (h_cnt_o < HW'(H_ACTIVE)) && (v_cnt_o < VW'(V_ACTIVE));
        hsync_n_o   = !((h_cnt_o >= HS_BEG) && (h_cnt_o < HS_END));
        vsync_n_o   = !((v_cnt_o >= VS_BEG) && (v_cnt_o < VS_END));
        frame_end_o = (h_cnt_o == H_LAST) && (v_cnt_o == V_LAST);
    end

    // R1: a line ends by returning the column to zero.
    a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt_o == H_LAST) |=> (h_cnt_o == '0));
    // R1: the row only moves when a line ends.
    a_r1_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt_o != H_LAST) |=> $stable(v_cnt_o));
endmodule

// File: rtl/fbscan_regs.sv
// Two write-only registers, staged and copied to the live setting at frame end.
// Assumes byte offsets: 0 = base, 4 = control; other offsets are ignored.
module fbscan_regs
    import fbscan_pkg::*;
#(
    parameter int BASE_KEEP = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              frame_end_i,
    output scan_cfg_t         cfg_o
);
    localparam logic [ADDR_W-1:0] BASE_MASK = ~({ADDR_W{1'b1}} >> BASE_KEEP);
    localparam logic [REG_AW-1:0] OFS_BASE  = REG_AW'(0);
    localparam logic [REG_AW-1:0] OFS_CTRL  = REG_AW'(4);

    scan_cfg_t staged;

    // Capture software writes into the staged copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
        end else if (wr_en_i && wr_addr_i == OFS_BASE) begin
            staged.base <= wr_data_i & BASE_MASK;
        end else if (wr_en_i && wr_addr_i == OFS_CTRL) begin
            staged.en  <= wr_data_i[0];
            staged.rot <= wr_data_i[1];
        end
    end

    // Hand the staged copy to scanout only as a frame finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)           cfg_o <= '0;
        else if (frame_end_i) cfg_o <= staged;
    end

    // R7: the live setting never moves in the middle of a frame.
    a_r7_cfg_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(cfg_o));
endmodule

// File: rtl/fbscan_addr.sv
// Maps a raster position to a pixel word address, optionally mirrored.
// Assumes ROW_WORDS >= H_ACTIVE and the whole buffer fits below ADDR_W bits.
module fbscan_addr
    import fbscan_pkg::*;
#(
    parameter int H_ACTIVE  = 640,
    parameter int V_ACTIVE  = 480,
    parameter int ROW_WORDS = 1024,
    parameter int HW        = 10,
    parameter int VW        = 10
) (
    input  logic [HW-1:0]     h_i,
    input  logic [VW-1:0]     v_i,
    input  logic              active_i,
    input  scan_cfg_t         cfg_i,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_addr_o
);
    localparam logic [ADDR_W-1:0] COL_MAX = ADDR_W'(H_ACTIVE - 1);
    localparam logic [ADDR_W-1:0] ROW_MAX = ADDR_W'(V_ACTIVE - 1);
    localparam logic [ADDR_W-1:0] STRIDE  = ADDR_W'(ROW_WORDS);

    logic [ADDR_W-1:0] row_sel, col_sel, word_idx;

    // Pick scan direction, form the word index and the byte address.
    always_comb begin
        row_sel    = cfg_i.rot ? ROW_MAX - ADDR_W'(v_i) : ADDR_W'(v_i);
        col_sel    = cfg_i.rot ? COL_MAX - ADDR_W'(h_i) : ADDR_W'(h_i);
        word_idx   = row_sel * STRIDE + col_sel;
        rd_addr_o  = cfg_i.base + (word_idx << 2);
        rd_valid_o = active_i && cfg_i.en;
    end
endmodule

// File: rtl/fbscan_pixout.sv
// Two-stage output pipeline: waits for the returned word, then splits it.
// Assumes memory returns the word exactly one clock after the request.
module fbscan_pixout
    import fbscan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               de_i,
    input  logic               fetch_i,
    input  logic               hsync_n_i,
    input  logic               vsync_n_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic               de_o,
    output logic [COLOR_W-1:0] red_o,
    output logic [COLOR_W-1:0] green_o,
    output logic [COLOR_W-1:0] blue_o,
    output logic               hsync_n_o,
    output logic               vsync_n_o
);
    logic de_q, fetch_q, hs_q, vs_q;
    logic unused_top_byte;

    assign unused_top_byte = ^word_i[WORD_W-1:3*COLOR_W];

    // Stage 1: hold raster flags while the memory answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q <= 1'b0; fetch_q <= 1'b0; hs_q <= 1'b1; vs_q <= 1'b1;
        end else begin
            de_q <= de_i; fetch_q <= fetch_i; hs_q <= hsync_n_i; vs_q <= vsync_n_i;
        end
    end

    // Stage 2: register colours (black unless a word was fetched) with flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_o <= 1'b0; hsync_n_o <= 1'b1; vsync_n_o <= 1'b1;
            {red_o, green_o, blue_o} <= '0;
        end else begin
            de_o      <= de_q;
            hsync_n_o <= hs_q;
            vsync_n_o <= vs_q;
            {red_o, green_o, blue_o} <= fetch_q ? word_i[3*COLOR_W-1:0] : '0;
        end
    end

    // R9: blanked positions always show black.
    a_r9_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> ({red_o, green_o, blue_o} == '0));
endmodule

// File: rtl/fbscan_top.sv
// Frame buffer scanout: raster timing, register staging, address
// generation and pixel unpacking for a fixed-size true-colour display.
// Assumes a one-clock fixed read latency on the memory side.
module fbscan_top
    import fbscan_pkg::*;
#(
    parameter int H_ACTIVE  = 640,
    parameter int H_FRONT   = 16,
    parameter int H_SYNC    = 96,
    parameter int H_BACK    = 48,
    parameter int V_ACTIVE  = 480,
    parameter int V_FRONT   = 10,
    parameter int V_SYNC    = 2,
    parameter int V_BACK    = 33,
    parameter int ROW_WORDS = 1024,
    parameter int BASE_KEEP = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_wr_addr,
    input  logic [31:0] reg_wr_data,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic [31:0] mem_rd_data,
    output logic        pix_de,
    output logic [7:0]  pix_red,
    output logic [7:0]  pix_green,
    output logic [7:0]  pix_blue,
    output logic        pix_hsync_n,
    output logic        pix_vsync_n
);
    localparam int HW = $clog2(H_ACTIVE + H_FRONT + H_SYNC + H_BACK);
    localparam int VW = $clog2(V_ACTIVE + V_FRONT + V_SYNC + V_BACK);

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          active, hsync_n, vsync_n, frame_end;
    scan_cfg_t     cfg;

    fbscan_raster #(
        .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
        .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
    ) u_raster (
        .clk(clk), .rst_n(rst_n), .h_cnt_o(h_cnt), .v_cnt_o(v_cnt),
        .active_o(active), .hsync_n_o(hsync_n), .vsync_n_o(vsync_n),
        .frame_end_o(frame_end)
    );

    fbscan_regs #(.BASE_KEEP(BASE_KEEP)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_en), .wr_addr_i(reg_wr_addr),
        .wr_data_i(reg_wr_data), .frame_end_i(frame_end), .cfg_o(cfg)
    );

    fbscan_addr #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .ROW_WORDS(ROW_WORDS),
        .HW(HW), .VW(VW)
    ) u_addr (
        .h_i(h_cnt), .v_i(v_cnt), .active_i(active), .cfg_i(cfg),
        .rd_valid_o(mem_rd_valid), .rd_addr_o(mem_rd_addr)
    );

    fbscan_pixout u_pixout (
        .clk(clk), .rst_n(rst_n), .de_i(active), .fetch_i(mem_rd_valid),
        .hsync_n_i(hsync_n), .vsync_n_i(vsync_n), .word_i(mem_rd_data),
        .de_o(pix_de), .red_o(pix_red), .green_o(pix_green), .blue_o(pix_blue),
        .hsync_n_o(pix_hsync_n), .vsync_n_o(pix_vsync_n)
    );

    // R6: a switched-off display never requests memory.
    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !mem_rd_valid);
    // R4: consecutive reads in normal order advance by one word.
    a_r4_forward_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && $past(mem_rd_valid) && !cfg.rot)
            |-> (mem_rd_addr == $past(mem_rd_addr) + 32'd4));
    // R5: consecutive reads in rotated order step back by one word.
    a_r5_reverse_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && $past(mem_rd_valid) && cfg.rot)
            |-> (mem_rd_addr == $past(mem_rd_addr) - 32'd4));
endmodule

// File: tb/test_fbscan_top.sv
`timescale 1ns/1ps
module test_fbscan_top;
    localparam int HA = 6, HF = 1, HS = 2, HB = 1;
    localparam int VA = 4, VF = 1, VS = 1, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int RW = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        pix_de, pix_hsync_n, pix_vsync_n;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench raster and register model.
    int mh = 0, mv = 0;
    logic [31:0] st_base = '0, lv_base = '0;
    logic st_en = 0, st_rot = 0, lv_en = 0, lv_rot = 0;
    // Two-deep history of expected outputs: {de, hs_n, vs_n, rgb}.
    logic [26:0] hist1, hist2;
    localparam logic [26:0] OUT_RST = {1'b0, 1'b1, 1'b1, 24'h0};

    always #5 clk = ~clk;

    fbscan_top #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
        .ROW_WORDS(RW), .BASE_KEEP(11)
    ) i_fbscan_top (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .pix_de(pix_de),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
        .pix_hsync_n(pix_hsync_n), .pix_vsync_n(pix_vsync_n)
    );

    // Memory content derived from the address; the top byte is never zero.
    function automatic logic [31:0] memf(input logic [31:0] a);
        return {8'hE7 ^ a[31:24], a[9:2] ^ 8'h5C, a[17:10] ^ 8'hA3, a[25:18] ^ a[28:21]};
    endfunction

    // One-clock memory with garbage when no read was requested.
    always_ff @(posedge clk)
        mem_rd_data <= mem_rd_valid ? memf(mem_rd_addr) : 32'hBAD0_0BAD;

    function automatic logic exp_act(input int h, input int v);
        return (h < HA) && (v < VA);
    endfunction

    function automatic logic [31:0] exp_addr(input int h, input int v);
        int r, c;
        r = lv_rot ? (VA - 1 - v) : v;
        c = lv_rot ? (HA - 1 - h) : h;
        return lv_base + 32'((r * RW + c) * 4);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at row %0d col %0d: actual %h expected %h",
                     tag, what, mv, mh, act, exp);
        end
    endtask

    // One clock: model the edge, then check the ports at the falling edge.
    task automatic step(input string rtag, input string ptag);
        logic act, vld, hs, vs;
        logic [31:0] w;
        act = exp_act(mh, mv);
        vld = act && lv_en;
        hs  = !((mh >= HA + HF) && (mh < HA + HF + HS));
        vs  = !((mv >= VA + VF) && (mv < VA + VF + VS));
        w   = vld ? memf(exp_addr(mh, mv)) : 32'h0;
        hist2 = hist1;
        hist1 = {act, hs, vs, w[23:0]};
        if (mh == HT - 1 && mv == VT - 1) begin
            lv_base = st_base; lv_en = st_en; lv_rot = st_rot;
        end
        if (reg_wr_en && reg_wr_addr == 3'd0) st_base = reg_wr_data & 32'hFFE0_0000;
        else if (reg_wr_en && reg_wr_addr == 3'd4) begin
            st_en = reg_wr_data[0]; st_rot = reg_wr_data[1];
        end
        if (mh == HT - 1) begin
            mh = 0;
            mv = (mv == VT - 1) ? 0 : mv + 1;
        end else mh++;
        @(negedge clk);
        chk(rtag, "rd_valid", 32'(mem_rd_valid), 32'(exp_act(mh, mv) && lv_en));
        if (exp_act(mh, mv) && lv_en) chk(rtag, "rd_addr", mem_rd_addr, exp_addr(mh, mv));
        chk(ptag, "de", 32'(pix_de), 32'(hist2[26]));
        chk(ptag, "rgb", {8'h0, pix_red, pix_green, pix_blue}, {8'h0, hist2[23:0]});
        chk("R1", "hsync_n", 32'(pix_hsync_n), 32'(hist2[25]));
        chk("R1", "vsync_n", 32'(pix_vsync_n), 32'(hist2[24]));
    endtask

    task automatic run(input int n, input string rtag, input string ptag);
        for (int i = 0; i < n; i++) step(rtag, ptag);
    endtask

    task automatic to_frame_start(input string rtag, input string ptag);
        while (!(mh == 0 && mv == 0)) step(rtag, ptag);
    endtask

    task automatic reg_write(input logic [2:0] ofs, input logic [31:0] d,
                             input string rtag, input string ptag);
        reg_wr_en = 1'b1; reg_wr_addr = ofs; reg_wr_data = d;
        step(rtag, ptag);
        reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
    endtask

    // R10: state held during and right after reset.
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "rd_valid", 32'(mem_rd_valid), 32'h0);
        chk("R10", "de", 32'(pix_de), 32'h0);
        chk("R10", "rgb", {8'h0, pix_red, pix_green, pix_blue}, 32'h0);
        chk("R10", "syncs", {30'h0, pix_hsync_n, pix_vsync_n}, 32'h3);
        rst_n = 1'b1;
        mh = 0; mv = 0; hist1 = OUT_RST; hist2 = OUT_RST;
        st_base = '0; lv_base = '0; st_en = 0; st_rot = 0; lv_en = 0; lv_rot = 0;
        run(2, "R10", "R10");
    endtask

    // R6/R9: display off after reset, a whole frame stays black and quiet.
    task automatic t_off_frame;
        run(HT * VT, "R6", "R9");
    endtask

    // R3/R7/R4/R8: set base with low bits, enable mid-frame, then scan.
    task automatic t_enable;
        to_frame_start("R6", "R9");
        run(5, "R6", "R9");
        reg_write(3'd0, 32'h1234_5678, "R7", "R7");
        reg_write(3'd4, 32'h0000_0001, "R7", "R7");
        to_frame_start("R7", "R7");
        run(HT * VT, "R4", "R8");
        run(HT * VT, "R3", "R8");
    endtask

    // R5: mirrored scan, also switched on mid-frame.
    task automatic t_rotate;
        run(HT + 3, "R4", "R8");
        reg_write(3'd4, 32'h0000_0003, "R7", "R8");
        to_frame_start("R7", "R8");
        run(2 * HT * VT, "R5", "R8");
    endtask

    // R2: writes to other offsets leave both registers alone.
    task automatic t_bad_offsets;
        run(HT + 1, "R5", "R8");
        reg_write(3'd1, 32'h0000_0000, "R2", "R2");
        reg_write(3'd2, 32'hFFFF_FFFF, "R2", "R2");
        reg_write(3'd7, 32'h0000_0000, "R2", "R2");
        reg_write(3'd0, 32'hABE0_0011, "R2", "R2");
        to_frame_start("R2", "R2");
        run(HT * VT, "R2", "R2");
    endtask

    // R6: writing zero to control switches the panel off at the next frame.
    task automatic t_turn_off;
        run(HT * 2 + 2, "R5", "R8");
        reg_write(3'd4, 32'h0, "R7", "R7");
        to_frame_start("R7", "R7");
        run(HT * VT, "R6", "R6");
        reg_write(3'd4, 32'h1, "R6", "R6");
        to_frame_start("R6", "R6");
        run(HT * VT, "R4", "R8");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_off_frame();
        t_enable();
        t_rotate();
        t_bad_offsets();
        t_turn_off();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule